// File: doc/BRIEF.md
# Unsigned Halfword Load Lane Unit

This block carries the address and data path of a halfword load that kernel code issues against the user address space. On an issue cycle it adds a sign-extended 9-bit displacement to a base register value to form the effective address. In the same cycle it applies the enable, segment-permission and alignment checks and reports at most one exception cause. The translated physical address comes back from outside the block. The unit swaps its low three bits for reverse-endian operation before the address goes to memory.

When the 64-bit memory doubleword returns for a load that issued cleanly, the unit picks the addressed 16-bit lane, taking the big-endian control into account. It zero-extends the lane to the register width and presents it one cycle later with a valid strobe. Address translation, the memory bus and register writeback stay outside the block.

A static parameter chooses between two alignment modes. In strict mode an odd address faults. In tolerant mode an odd address is allowed, and only a halfword that would cross the doubleword boundary is rejected.

Top module: `uhw_load_unit`

## Requirements
- R1: While `issue_i` is high, `ea_o` equals `base_i` plus `offset_i` sign-extended from 9 bits, modulo 2^XLEN.
- R2: `mem_paddr_o` equals `paddr_i` with bits [2:0] XORed with {`rev_endian_i`, 2'b00}. All higher bits pass through unchanged.
- R3: The lane index is `ea_o[2:0]` XOR {`big_endian_i`, 2'b00}, captured at issue. The loaded value is `resp_data_i[8*idx+15 : 8*idx]`, and bits XLEN-1..16 of `data_o` are zero.
- R4: `data_valid_o` is high for exactly the cycle after a cycle in which `resp_valid_i` is high while a clean load is pending. It is low at every other time.
- R5: An issue with `feat_en_i` low raises `exc_ri_o` and no other cause.
- R6: An issue with `feat_en_i` high raises `exc_cpu_o` when either `cop0_en_i` is low or `seg_mode_i` is not one of the permitted codes. The permitted codes are 3 (mapped for user, supervisor and kernel), 4 (mapped for user, unmapped for kernel) and 5 (unmapped for all).
- R7: With STRICT_ALIGN=1, an issue that passes R5 and R6 raises `exc_ade_o` when `ea_o[0]` is 1.
- R8: With STRICT_ALIGN=0, odd addresses do not fault. An issue that passes R5 and R6 raises `exc_span_o` when the lane index of R3 equals 7.
- R9: The four exception outputs are one-hot or all zero. They are all zero when `issue_i` is low. Priority runs RI, then CPU, then ADE, then SPAN.
- R10: An issue that raises any exception cancels the load, so its response yields no `data_valid_o`. A response that arrives with no pending load is ignored.
- R11: After reset, `data_valid_o` and `data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Load issue strobe |
| base_i | input | XLEN | Base register value |
| offset_i | input | 9 | Signed displacement |
| big_endian_i | input | 1 | Core runs big-endian |
| rev_endian_i | input | 1 | Reverse-endian mode for the current context |
| seg_mode_i | input | 3 | Access-mode code of the target segment |
| cop0_en_i | input | 1 | Privileged coprocessor access enabled |
| feat_en_i | input | 1 | Feature present and enabled |
| ea_o | output | XLEN | Effective address |
| exc_ri_o | output | 1 | Reserved-instruction cause |
| exc_cpu_o | output | 1 | Coprocessor-unusable cause |
| exc_ade_o | output | 1 | Address-error cause |
| exc_span_o | output | 1 | Doubleword-straddle cause (tolerant mode only) |
| paddr_i | input | PA_W | Translated physical address |
| mem_paddr_o | output | PA_W | Physical address sent to memory |
| resp_valid_i | input | 1 | Memory doubleword valid |
| resp_data_i | input | 64 | Memory doubleword |
| data_valid_o | output | 1 | Loaded value valid |
| data_o | output | XLEN | Zero-extended halfword |

## Verification
A new issue and the memory response of the previous load can land in the same cycle. When they do, the response must be completed with the lane index captured for the older load, and the new issue must replace the pending state. The bench provokes this by driving a second issue in the same cycle as the first load's response. It then checks that the value presented next cycle matches the first load's address and endianness, and that the second load completes on its own response. If the second issue faults, the bench checks that its response is dropped.

// File: rtl/uhl_pkg.sv
package uhl_pkg;
  typedef enum logic [2:0] {
    SEG_K_UNMAP     = 3'd0,
    SEG_K_MAP       = 3'd1,
    SEG_SK_MAP      = 3'd2,
    SEG_USK_MAP     = 3'd3,
    SEG_U_MAP_K_RAW = 3'd4,
    SEG_ALL_UNMAP   = 3'd5,
    SEG_RSV6        = 3'd6,
    SEG_RSV7        = 3'd7
  } seg_mode_e;

  typedef struct packed {
    logic ri;
    logic cpu;
    logic ade;
    logic span;
  } exc_t;

  function automatic logic seg_allowed(logic [2:0] code);
    seg_mode_e m;
    m = seg_mode_e'(code);
    return (m == SEG_USK_MAP) || (m == SEG_U_MAP_K_RAW) || (m == SEG_ALL_UNMAP);
  endfunction
endpackage

// File: rtl/uhl_addr_gen.sv
module uhl_addr_gen #(
  parameter int XLEN   = 64,
  parameter int OFF_W  = 9,
  parameter int BIDX_W = 3
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              big_endian_i,
  output logic [XLEN-1:0]   ea_o,
  output logic [BIDX_W-1:0] lane_o,
  output logic              odd_o,
  output logic              straddle_o
);
  localparam logic [BIDX_W-1:0] LAST_LANE = '1;

  logic [XLEN-1:0] off_sx;

  assign off_sx     = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign ea_o       = base_i + off_sx;
  // big-endian flips the top index bit
  assign lane_o     = ea_o[BIDX_W-1:0] ^ {big_endian_i, {(BIDX_W-1){1'b0}}};
  assign odd_o      = ea_o[0];
  assign straddle_o = (lane_o == LAST_LANE);
endmodule

// File: rtl/uhl_perm_check.sv
module uhl_perm_check
  import uhl_pkg::*;
#(
  parameter bit STRICT_ALIGN = 1'b1
) (
  input  logic       issue_i,
  input  logic       feat_en_i,
  input  logic       cop0_en_i,
  input  logic [2:0] seg_mode_i,
  input  logic       odd_i,
  input  logic       straddle_i,
  output exc_t       exc_o
);
  logic align_bad;

  generate
    if (STRICT_ALIGN) begin : g_strict
      assign align_bad = odd_i;
    end else begin : g_tolerant
      assign align_bad = straddle_i;
    end
  endgenerate

  always_comb begin
    exc_o = '0;
    if (issue_i) begin
      if (!feat_en_i)                                  exc_o.ri  = 1'b1;
      else if (!cop0_en_i || !seg_allowed(seg_mode_i)) exc_o.cpu = 1'b1;
      else if (align_bad) begin
        if (STRICT_ALIGN) exc_o.ade  = 1'b1;
        else              exc_o.span = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uhl_lane_sel.sv
module uhl_lane_sel #(
  parameter int DW     = 64,
  parameter int BIDX_W = 3
) (
  input  logic [DW-1:0]     dw_i,
  input  logic [BIDX_W-1:0] lane_i,
  output logic [15:0]       hw_o
);
  localparam int NBYTES = DW / 8;

  logic [15:0] cand [NBYTES];

  generate
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      if (k < NBYTES - 1) begin : g_full
        assign cand[k] = dw_i[8*k +: 16];
      end else begin : g_edge
        // never selected for a clean load
        assign cand[k] = {8'h00, dw_i[8*k +: 8]};
      end
    end
  endgenerate

  assign hw_o = cand[lane_i];
endmodule

// File: rtl/uhw_load_unit.sv
module uhw_load_unit
  import uhl_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter int PA_W         = 40,
  parameter bit STRICT_ALIGN = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [8:0]      offset_i,
  input  logic            big_endian_i,
  input  logic            rev_endian_i,
  input  logic [2:0]      seg_mode_i,
  input  logic            cop0_en_i,
  input  logic            feat_en_i,
  output logic [XLEN-1:0] ea_o,
  output logic            exc_ri_o,
  output logic            exc_cpu_o,
  output logic            exc_ade_o,
  output logic            exc_span_o,
  input  logic [PA_W-1:0] paddr_i,
  output logic [PA_W-1:0] mem_paddr_o,
  input  logic            resp_valid_i,
  input  logic [63:0]     resp_data_i,
  output logic            data_valid_o,
  output logic [XLEN-1:0] data_o
);
  localparam int DW     = 64;
  localparam int OFF_W  = 9;
  localparam int BIDX_W = $clog2(DW / 8);

  logic [BIDX_W-1:0] lane_now, lane_q;
  logic              odd, straddle, pend_q;
  logic [15:0]       hw;
  exc_t              exc;

  uhl_addr_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .BIDX_W(BIDX_W)) i_addr (
    .base_i(base_i), .offset_i(offset_i), .big_endian_i(big_endian_i),
    .ea_o(ea_o), .lane_o(lane_now), .odd_o(odd), .straddle_o(straddle)
  );

  uhl_perm_check #(.STRICT_ALIGN(STRICT_ALIGN)) i_perm (
    .issue_i(issue_i), .feat_en_i(feat_en_i), .cop0_en_i(cop0_en_i),
    .seg_mode_i(seg_mode_i), .odd_i(odd), .straddle_i(straddle), .exc_o(exc)
  );

  uhl_lane_sel #(.DW(DW), .BIDX_W(BIDX_W)) i_lane (
    .dw_i(resp_data_i), .lane_i(lane_q), .hw_o(hw)
  );

  assign exc_ri_o   = exc.ri;
  assign exc_cpu_o  = exc.cpu;
  assign exc_ade_o  = exc.ade;
  assign exc_span_o = exc.span;

  assign mem_paddr_o = {paddr_i[PA_W-1:BIDX_W],
                        paddr_i[BIDX_W-1:0] ^ {rev_endian_i, {(BIDX_W-1){1'b0}}}};

  // a new issue replaces pending state; the response in the same cycle uses lane_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lane_q <= '0;
    end else if (issue_i) begin
      pend_q <= (exc == '0);
      lane_q <= lane_now;
    end else if (resp_valid_i) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_valid_o <= 1'b0;
      data_o       <= '0;
    end else begin
      data_valid_o <= resp_valid_i && pend_q;
      if (resp_valid_i && pend_q) data_o <= {{(XLEN-16){1'b0}}, hw};
    end
  end
endmodule

// File: rtl/uhl_checker.sv
module uhl_checker #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_i,
  input logic            feat_en_i,
  input logic            exc_ri_o,
  input logic            exc_cpu_o,
  input logic            exc_ade_o,
  input logic            exc_span_o,
  input logic            resp_valid_i,
  input logic            data_valid_o,
  input logic [XLEN-1:0] data_o
);
  logic any_exc;
  assign any_exc = exc_ri_o | exc_cpu_o | exc_ade_o | exc_span_o;

  AST_EXC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({exc_ri_o, exc_cpu_o, exc_ade_o, exc_span_o})); // R9

  AST_EXC_NEEDS_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_exc |-> issue_i); // R9

  AST_RI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !feat_en_i) |-> (exc_ri_o && !exc_cpu_o && !exc_ade_o && !exc_span_o)); // R5

  AST_VALID_AFTER_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_i |=> !data_valid_o); // R4

  AST_FAULT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && any_exc) ##1 resp_valid_i |=> !data_valid_o); // R10

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (data_o[XLEN-1:16] == '0)); // R3
endmodule

bind uhw_load_unit uhl_checker #(.XLEN(XLEN)) i_uhl_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .feat_en_i(feat_en_i),
  .exc_ri_o(exc_ri_o), .exc_cpu_o(exc_cpu_o), .exc_ade_o(exc_ade_o),
  .exc_span_o(exc_span_o), .resp_valid_i(resp_valid_i),
  .data_valid_o(data_valid_o), .data_o(data_o)
);

// File: tb/test_uhw_load_unit.sv
`timescale 1ns/1ps
module test_uhw_load_unit;
  localparam int XLEN = 64;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [XLEN-1:0] base = '0;
  logic [8:0] off = '0;
  logic be = 1'b0, rev = 1'b0, cop = 1'b1, fe = 1'b1;
  logic [2:0] seg = 3'd3;
  logic [PA_W-1:0] pa = '0;
  logic resp_v = 1'b0;
  logic [63:0] resp_d = '0;

  logic [XLEN-1:0] ea_s, ea_t, dat_s, dat_t;
  logic ri_s, cpu_s, ade_s, spn_s, ri_t, cpu_t, ade_t, spn_t, dv_s, dv_t;
  logic [PA_W-1:0] mpa_s, mpa_t;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uhw_load_unit #(.XLEN(XLEN), .PA_W(PA_W), .STRICT_ALIGN(1'b1)) i_uhw_load_unit (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .base_i(base), .offset_i(off),
    .big_endian_i(be), .rev_endian_i(rev), .seg_mode_i(seg), .cop0_en_i(cop),
    .feat_en_i(fe), .ea_o(ea_s), .exc_ri_o(ri_s), .exc_cpu_o(cpu_s),
    .exc_ade_o(ade_s), .exc_span_o(spn_s), .paddr_i(pa), .mem_paddr_o(mpa_s),
    .resp_valid_i(resp_v), .resp_data_i(resp_d), .data_valid_o(dv_s), .data_o(dat_s)
  );

  uhw_load_unit #(.XLEN(XLEN), .PA_W(PA_W), .STRICT_ALIGN(1'b0)) i_uhw_load_unit_tol (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .base_i(base), .offset_i(off),
    .big_endian_i(be), .rev_endian_i(rev), .seg_mode_i(seg), .cop0_en_i(cop),
    .feat_en_i(fe), .ea_o(ea_t), .exc_ri_o(ri_t), .exc_cpu_o(cpu_t),
    .exc_ade_o(ade_t), .exc_span_o(spn_t), .paddr_i(pa), .mem_paddr_o(mpa_t),
    .resp_valid_i(resp_v), .resp_data_i(resp_d), .data_valid_o(dv_t), .data_o(dat_t)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] f_ea(logic [63:0] b, logic [8:0] o);
    return b + {{55{o[8]}}, o};
  endfunction

  function automatic logic [2:0] f_lane(logic [63:0] ea, logic bend);
    return ea[2:0] ^ {bend, 2'b00};
  endfunction

  // {ri, cpu, ade, span}
  function automatic logic [3:0] f_exc(logic f, logic c, logic [2:0] s, logic [63:0] ea,
                                       logic bend, bit strict);
    if (!f) return 4'b1000;
    if (!c || !(s inside {3'd3, 3'd4, 3'd5})) return 4'b0100;
    if (strict && ea[0]) return 4'b0010;
    if (!strict && f_lane(ea, bend) == 3'd7) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic string f_req(logic [3:0] e, bit strict);
    if (e[3]) return "R5";
    if (e[2]) return "R6";
    if (e[1]) return "R7";
    if (e[0]) return "R8";
    return strict ? "R9" : "R8";
  endfunction

  function automatic logic [63:0] f_data(logic [63:0] d, logic [2:0] lane);
    return (d >> (8 * lane)) & 64'h0000_0000_0000_ffff;
  endfunction

  task automatic drive_issue(logic [63:0] b, logic [8:0] o, logic bend, logic r,
                             logic [2:0] s, logic c, logic f,
                             output logic [3:0] es, output logic [3:0] et,
                             output logic [2:0] lane);
    logic [63:0] ea;
    issue = 1'b1; base = b; off = o; be = bend; rev = r; seg = s; cop = c; fe = f;
    #1;
    ea = f_ea(b, o);
    es = f_exc(f, c, s, ea, bend, 1'b1);
    et = f_exc(f, c, s, ea, bend, 1'b0);
    lane = f_lane(ea, bend);
    chk("R1", ea_s, ea);
    chk("R1", ea_t, ea);
    chk(f_req(es, 1'b1), {60'd0, ri_s, cpu_s, ade_s, spn_s}, {60'd0, es});
    chk(f_req(et, 1'b0), {60'd0, ri_t, cpu_t, ade_t, spn_t}, {60'd0, et});
  endtask

  task automatic check_result(logic [3:0] es, logic [3:0] et, logic [2:0] lane,
                              logic [63:0] d);
    chk((es == 0) ? "R4" : "R10", {63'd0, dv_s}, {63'd0, (es == 0)});
    chk((et == 0) ? "R4" : "R10", {63'd0, dv_t}, {63'd0, (et == 0)});
    if (es == 0) chk("R3", dat_s, f_data(d, lane));
    if (et == 0) chk("R3", dat_t, f_data(d, lane));
  endtask

  task automatic one_load(logic [63:0] b, logic [8:0] o, logic bend, logic r,
                          logic [2:0] s, logic c, logic f, logic [63:0] d,
                          logic [PA_W-1:0] p);
    logic [3:0] es, et;
    logic [2:0] lane;
    @(negedge clk);
    resp_v = 1'b0;
    drive_issue(b, o, bend, r, s, c, f, es, et, lane);
    @(negedge clk);
    issue = 1'b0; resp_v = 1'b1; resp_d = d; pa = p;
    #1;
    chk("R2", {24'd0, mpa_s}, {24'd0, p[PA_W-1:3], p[2:0] ^ {r, 2'b00}});
    @(posedge clk);
    #1;
    check_result(es, et, lane, d);
    @(negedge clk);
    resp_v = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] es_a, et_a, es_b, et_b;
    logic [2:0] ln_a, ln_b;
    int unsigned seed;
    seed = $urandom(32'd1207);

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {63'd0, dv_s}, 64'd0);
    chk("R11", dat_s, 64'd0);
    chk("R11", dat_t, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 idle: no causes without issue
    chk("R9", {60'd0, ri_s, cpu_s, ade_s, spn_s, 4'd0} >> 4, 64'd0);

    // directed corners
    one_load(64'h1000, 9'h100, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 64'h8877_6655_4433_2211, 40'h12_3456_7800); // R1 -256
    one_load(64'h2001, 9'h0ff, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, 64'hfedc_ba98_7654_3210, 40'hab_cdef_0127); // R1 +255
    one_load(64'hffff_ffff_ffff_fff0, 9'h010, 1'b0, 1'b0, 3'd5, 1'b1, 1'b1, 64'h0123_4567_89ab_cdef, 40'h0); // R1 wrap
    one_load(64'h3006, 9'h0, 1'b0, 1'b0, 3'd5, 1'b1, 1'b1, 64'hbeef_0000_0000_0000, 40'h7); // R3 top lane
    one_load(64'h3007, 9'h0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 64'h1111_2222_3333_4444, 40'h7); // R8 straddle
    one_load(64'h3003, 9'h0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b1, 64'h1111_2222_3333_4444, 40'h3); // R8 straddle BE
    one_load(64'h3005, 9'h0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 64'h1111_2222_3333_4444, 40'h3); // R7 vs R8 odd ok
    one_load(64'h3001, 9'h0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 64'h55, 40'h0); // R5 over R6, R7
    one_load(64'h3001, 9'h0, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 64'h55, 40'h0); // R6 seg
    one_load(64'h3001, 9'h0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 64'h55, 40'h0); // R6 cop0 over R7

    // R10 stray response
    @(negedge clk);
    resp_v = 1'b1; resp_d = 64'hdead_beef_dead_beef;
    @(posedge clk); #1;
    chk("R10", {62'd0, dv_s, dv_t}, 64'd0);
    @(negedge clk); resp_v = 1'b0;

    // overlap: response of A with issue of B in the same cycle
    @(negedge clk);
    drive_issue(64'h4002, 9'h0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, es_a, et_a, ln_a);
    @(negedge clk);
    resp_v = 1'b1; resp_d = 64'h0a0b_0c0d_0e0f_1234;
    drive_issue(64'h4004, 9'h0, 1'b1, 1'b0, 3'd5, 1'b1, 1'b1, es_b, et_b, ln_b);
    @(posedge clk); #1;
    check_result(es_a, et_a, ln_a, 64'h0a0b_0c0d_0e0f_1234); // R3 older lane kept
    @(negedge clk);
    issue = 1'b0; resp_d = 64'h9999_8888_7777_6666;
    @(posedge clk); #1;
    check_result(es_b, et_b, ln_b, 64'h9999_8888_7777_6666); // R4 second load
    @(negedge clk); resp_v = 1'b0;

    // overlap where the new issue faults: its response is dropped
    @(negedge clk);
    drive_issue(64'h5000, 9'h0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, es_a, et_a, ln_a);
    @(negedge clk);
    resp_v = 1'b1; resp_d = 64'h0000_0000_abcd_ef01;
    drive_issue(64'h5000, 9'h0, 1'b0, 1'b0, 3'd3, 1'b1, 1'b0, es_b, et_b, ln_b);
    @(posedge clk); #1;
    check_result(es_a, et_a, ln_a, 64'h0000_0000_abcd_ef01);
    @(negedge clk);
    issue = 1'b0;
    @(posedge clk); #1;
    chk("R10", {62'd0, dv_s, dv_t}, 64'd0);
    @(negedge clk); resp_v = 1'b0;

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [63:0] rb, rd;
      logic [PA_W-1:0] rp;
      rb = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      rp = {$urandom, $urandom};
      one_load(rb, 9'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
               ($urandom % 10) != 0, ($urandom % 10) != 0, rd, rp);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule